// File: doc/BRIEF.md
# Word Reservation Tracker for Conditional Stores

This block holds one address reservation for an atomic read-modify-write sequence. A reserving load records that the reservation is live, how many bytes it covers, and its effective address. A later conditional store asks the block whether it may go ahead. The block answers one cycle after the request with a pass/fail flag and a 4-bit condition field. It also gates the store's write enable, write address and 32-bit write data.

Any conditional store consumes the reservation, whether it passes or fails. An external invalidate input can drop the reservation at any time, for example on a conflicting access seen elsewhere. Coherence snooping and the memory write itself are outside this block. The block only produces the qualified write request.

Top module: `rsv_unit`

## Requirements
- R1: A reserving load (`lr_req`) makes the reservation live on the next cycle and records its length and address. The recorded values are observable through a later conditional store.
- R2: A conditional store fails when no reservation is live.
- R3: A conditional store fails when the recorded reservation length is not 4 bytes.
- R4: A conditional store passes only when the recorded address equals its own address. When it passes, the reservation is live, both lengths are 4 and the addresses match.
- R5: After any conditional store, passed or failed, the reservation is no longer live, unless a reserving load arrives in the same cycle.
- R6: `res_vld` is high exactly in the cycle after each conditional store request. `res_cr` is then {LT=0, GT=0, EQ=pass, SO=0}, with EQ at bit 1 and bits 3, 2 and 0 at zero.
- R7: `wr_en` is high together with the result only when the store passes. `wr_addr` then equals the store address and `wr_data` equals bits 31:0 of the source operand.
- R8: A new reserving load replaces any existing reservation's length and address.
- R9: `inval` clears the reservation. When `inval` and `lr_req` occur in the same cycle, the reservation is set.
- R10: Synchronous reset clears the reservation and drives `res_vld`, `res_pass`, `wr_en` and `res_cr` to zero.
- R11: A conditional store whose own length is not 4 bytes fails.
- R12: When a reserving load and a conditional store occur in the same cycle, the store is judged against the reservation held before that cycle, and the new reservation is live afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lr_req | input | 1 | Reserving load request |
| lr_addr | input | AW | Effective address of the reserving load |
| lr_len | input | LW | Byte length of the reserving load |
| sc_req | input | 1 | Conditional store request |
| sc_addr | input | AW | Effective address of the conditional store |
| sc_len | input | LW | Byte length of the conditional store |
| sc_data | input | DW | Source register value of the conditional store |
| inval | input | 1 | External reservation kill |
| rsv_live | output | 1 | Reservation currently live |
| res_vld | output | 1 | Result valid, one cycle after a store request |
| res_pass | output | 1 | Store performed |
| res_cr | output | 4 | Condition field {LT,GT,EQ,SO} |
| wr_en | output | 1 | Qualified memory write enable |
| wr_addr | output | AW | Write address |
| wr_data | output | 32 | Write data, low word of source |

## Verification
Every result output (`res_vld`, `res_pass`, `res_cr`, `wr_en`, `wr_addr`, `wr_data`) comes from a register loaded at the clock edge that samples the request. These outputs are due one cycle after the stimulus. `rsv_live` reflects the reservation update from that same edge. The bench drives inputs on the falling edge and samples all outputs shortly after the next rising edge. Each check therefore sees exactly the cycle in which the request was taken. The expected result is computed from a bench-side reservation model, and the model is advanced only after the outputs have been checked.

// File: rtl/rsv_pkg.sv
package rsv_pkg;
  localparam int WORD_BYTES = 4;
  localparam int WORD_BITS  = 32;
  localparam int CR_W       = 4;
  localparam int CR_LT      = 3;
  localparam int CR_GT      = 2;
  localparam int CR_EQ      = 1;
  localparam int CR_SO      = 0;

  function automatic logic [CR_W-1:0] make_cr(input logic eq);
    logic [CR_W-1:0] f;
    f        = '0;
    f[CR_EQ] = eq;
    return f;
  endfunction
endpackage

// File: rtl/rsv_store.sv
module rsv_store #(
  parameter int AW = 16,
  parameter int LW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          set_i,
  input  logic [AW-1:0] set_addr_i,
  input  logic [LW-1:0] set_len_i,
  input  logic          kill_i,
  output logic          live_o,
  output logic [AW-1:0] addr_o,
  output logic [LW-1:0] len_o
);
  logic          live_q;
  logic [AW-1:0] addr_q;
  logic [LW-1:0] len_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      live_q <= 1'b0;
      addr_q <= '0;
      len_q  <= '0;
    end else if (set_i) begin
      live_q <= 1'b1;
      addr_q <= set_addr_i;
      len_q  <= set_len_i;
    end else if (kill_i) begin
      live_q <= 1'b0;
    end
  end

  assign live_o = live_q;
  assign addr_o = addr_q;
  assign len_o  = len_q;
endmodule

// File: rtl/rsv_match.sv
module rsv_match #(
  parameter int AW = 16,
  parameter int LW = 4
) (
  input  logic          live_i,
  input  logic [AW-1:0] rsv_addr_i,
  input  logic [LW-1:0] rsv_len_i,
  input  logic [AW-1:0] st_addr_i,
  input  logic [LW-1:0] st_len_i,
  output logic          hit_o
);
  import rsv_pkg::*;
  localparam logic [LW-1:0] WLEN = LW'(WORD_BYTES);

  logic len_ok, st_ok, addr_ok;

  always_comb begin
    len_ok  = (rsv_len_i == WLEN);
    st_ok   = (st_len_i == WLEN);
    addr_ok = (rsv_addr_i == st_addr_i);
    hit_o   = live_i && len_ok && st_ok && addr_ok;
  end
endmodule

// File: rtl/rsv_result.sv
module rsv_result #(
  parameter int AW = 16,
  parameter int DW = 64
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   req_i,
  input  logic                   hit_i,
  input  logic [AW-1:0]          addr_i,
  input  logic [DW-1:0]          data_i,
  output logic                   vld_o,
  output logic                   pass_o,
  output logic [rsv_pkg::CR_W-1:0] cr_o,
  output logic                   wen_o,
  output logic [AW-1:0]          waddr_o,
  output logic [rsv_pkg::WORD_BITS-1:0] wdata_o
);
  import rsv_pkg::*;

  logic [WORD_BITS-1:0] low_word;

  generate
    if (DW > WORD_BITS) begin : g_slice
      assign low_word = data_i[WORD_BITS-1:0];
    end else begin : g_pad
      assign low_word = WORD_BITS'(data_i);
    end
  endgenerate

  logic go;
  assign go = req_i && hit_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_o   <= 1'b0;
      pass_o  <= 1'b0;
      cr_o    <= '0;
      wen_o   <= 1'b0;
      waddr_o <= '0;
      wdata_o <= '0;
    end else begin
      vld_o  <= req_i;
      pass_o <= go;
      cr_o   <= req_i ? make_cr(hit_i) : '0;
      wen_o  <= go;
      if (req_i) begin
        waddr_o <= addr_i;
        wdata_o <= low_word;
      end
    end
  end
endmodule

// File: rtl/rsv_unit.sv
module rsv_unit #(
  parameter int AW = 16,
  parameter int LW = 4,
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          lr_req,
  input  logic [AW-1:0] lr_addr,
  input  logic [LW-1:0] lr_len,
  input  logic          sc_req,
  input  logic [AW-1:0] sc_addr,
  input  logic [LW-1:0] sc_len,
  input  logic [DW-1:0] sc_data,
  input  logic          inval,
  output logic          rsv_live,
  output logic          res_vld,
  output logic          res_pass,
  output logic [3:0]    res_cr,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [31:0]   wr_data
);
  logic [AW-1:0] r_addr;
  logic [LW-1:0] r_len;
  logic          hit;

  rsv_store #(.AW(AW), .LW(LW)) u_store (
    .clk(clk), .rst(rst),
    .set_i(lr_req), .set_addr_i(lr_addr), .set_len_i(lr_len),
    .kill_i(sc_req || inval),
    .live_o(rsv_live), .addr_o(r_addr), .len_o(r_len)
  );

  rsv_match #(.AW(AW), .LW(LW)) u_match (
    .live_i(rsv_live), .rsv_addr_i(r_addr), .rsv_len_i(r_len),
    .st_addr_i(sc_addr), .st_len_i(sc_len), .hit_o(hit)
  );

  rsv_result #(.AW(AW), .DW(DW)) u_result (
    .clk(clk), .rst(rst),
    .req_i(sc_req), .hit_i(hit), .addr_i(sc_addr), .data_i(sc_data),
    .vld_o(res_vld), .pass_o(res_pass), .cr_o(res_cr),
    .wen_o(wr_en), .waddr_o(wr_addr), .wdata_o(wr_data)
  );
endmodule

// File: rtl/rsv_unit_chk.sv
module rsv_unit_chk (
  input logic clk,
  input logic rst,
  input logic lr_req,
  input logic sc_req,
  input logic inval,
  input logic rsv_live,
  input logic res_vld,
  input logic res_pass,
  input logic wr_en
);
  AST_LR_SETS: assert property (@(posedge clk) disable iff (rst)
    lr_req |=> rsv_live); // R9
  AST_SC_CONSUMES: assert property (@(posedge clk) disable iff (rst)
    (sc_req && !lr_req) |=> !rsv_live); // R5
  AST_INV_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (inval && !lr_req) |=> !rsv_live); // R9
  AST_RES_DUE: assert property (@(posedge clk) disable iff (rst)
    sc_req |=> res_vld); // R6
  AST_RES_QUIET: assert property (@(posedge clk) disable iff (rst)
    !sc_req |=> (!res_vld && !res_pass)); // R6
  AST_NEED_LIVE: assert property (@(posedge clk) disable iff (rst)
    (sc_req && !rsv_live) |=> !res_pass); // R2
  AST_WR_GATED: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (res_pass && res_vld)); // R7
endmodule

bind rsv_unit rsv_unit_chk u_chk (
  .clk(clk), .rst(rst), .lr_req(lr_req), .sc_req(sc_req), .inval(inval),
  .rsv_live(rsv_live), .res_vld(res_vld), .res_pass(res_pass), .wr_en(wr_en)
);

// File: tb/rsv_unit_tb_top.sv
module rsv_unit_tb_top;
  localparam int AW = 4;
  localparam int LW = 4;
  localparam int DW = 64;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          lr_req = 1'b0;
  logic [AW-1:0] lr_addr = '0;
  logic [LW-1:0] lr_len = '0;
  logic          sc_req = 1'b0;
  logic [AW-1:0] sc_addr = '0;
  logic [LW-1:0] sc_len = '0;
  logic [DW-1:0] sc_data = '0;
  logic          inval = 1'b0;
  logic          rsv_live, res_vld, res_pass, wr_en;
  logic [3:0]    res_cr;
  logic [AW-1:0] wr_addr;
  logic [31:0]   wr_data;

  int total = 0;
  int bad = 0;
  bit m_live = 0;
  logic [AW-1:0] m_addr = '0;
  logic [LW-1:0] m_len = '0;
  bit done = 0;

  always #4 clk = ~clk;

  rsv_unit #(.AW(AW), .LW(LW), .DW(DW)) dut_i (
    .clk(clk), .rst(rst), .lr_req(lr_req), .lr_addr(lr_addr), .lr_len(lr_len),
    .sc_req(sc_req), .sc_addr(sc_addr), .sc_len(sc_len), .sc_data(sc_data),
    .inval(inval), .rsv_live(rsv_live), .res_vld(res_vld), .res_pass(res_pass),
    .res_cr(res_cr), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input bit lr, input logic [AW-1:0] la, input logic [LW-1:0] ll,
                      input bit sc, input logic [AW-1:0] sa, input logic [LW-1:0] sl,
                      input logic [DW-1:0] sd, input bit iv, input string tag);
    bit ep;
    @(negedge clk);
    lr_req = lr; lr_addr = la; lr_len = ll;
    sc_req = sc; sc_addr = sa; sc_len = sl; sc_data = sd; inval = iv;
    ep = sc && m_live && (m_len == 4) && (m_addr == sa) && (sl == 4);
    if (sc || iv) m_live = 0;
    if (lr) begin m_live = 1; m_addr = la; m_len = ll; end
    @(posedge clk); #2;
    chk("R6 res_vld", res_vld, sc);
    if (sc) begin
      chk(tag, res_pass, ep);
      chk("R6 res_cr", res_cr, {2'b00, ep, 1'b0});
      chk("R7 wr_en", wr_en, ep);
      if (ep) begin
        chk("R7 wr_addr", wr_addr, sa);
        chk("R7 wr_data", wr_data, sd[31:0]);
      end
    end else begin
      chk("R7 wr_en idle", wr_en, 0);
    end
    chk("R5 rsv_live", rsv_live, m_live);
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0, 0, "idle");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    // R10 reset state
    chk("R10 live", rsv_live, 0);
    chk("R10 vld", res_vld, 0);
    chk("R10 pass", res_pass, 0);
    chk("R10 cr", res_cr, 0);
    chk("R10 wen", wr_en, 0);

    // R2 no reservation
    step(0, 0, 0, 1, 4'h3, 4, 64'h1, 0, "R2");
    // R1 / R4 basic pass
    step(1, 4'h5, 4, 0, 0, 0, 0, 0, "R1");
    step(0, 0, 0, 1, 4'h5, 4, 64'hDEAD_BEEF_1234_5678, 0, "R4 pass");
    // R5 consumed: second store fails
    step(0, 0, 0, 1, 4'h5, 4, 64'h2, 0, "R5 reuse");
    // R3 wrong reserved length
    step(1, 4'h6, 8, 0, 0, 0, 0, 0, "R1 len8");
    step(0, 0, 0, 1, 4'h6, 4, 64'h3, 0, "R3");
    // R11 wrong store length
    step(1, 4'h7, 4, 0, 0, 0, 0, 0, "R1");
    step(0, 0, 0, 1, 4'h7, 2, 64'h4, 0, "R11");
    // R8 overwrite
    step(1, 4'h1, 4, 0, 0, 0, 0, 0, "R1");
    step(1, 4'h2, 4, 0, 0, 0, 0, 0, "R8");
    step(0, 0, 0, 1, 4'h1, 4, 64'h5, 0, "R8 old addr");
    step(1, 4'h1, 4, 0, 0, 0, 0, 0, "R1");
    step(1, 4'h2, 8, 0, 0, 0, 0, 0, "R8 len");
    step(0, 0, 0, 1, 4'h2, 4, 64'h6, 0, "R8 new len");
    // R9 invalidate
    step(1, 4'h9, 4, 0, 0, 0, 0, 0, "R1");
    step(0, 0, 0, 0, 0, 0, 0, 1, "R9 inval");
    step(0, 0, 0, 1, 4'h9, 4, 64'h7, 0, "R9 after inval");
    step(1, 4'h9, 4, 0, 0, 0, 0, 1, "R9 lr wins");
    step(0, 0, 0, 1, 4'h9, 4, 64'hFFFF_FFFF_CAFE_F00D, 0, "R9 lr wins pass");
    // R12 same-cycle lr and sc
    step(1, 4'hA, 4, 0, 0, 0, 0, 0, "R1");
    step(1, 4'hB, 4, 1, 4'hA, 4, 64'h8, 0, "R12 old judged");
    step(0, 0, 0, 1, 4'hB, 4, 64'h9, 0, "R12 new live");
    step(1, 4'hC, 4, 1, 4'hC, 4, 64'hA, 0, "R12 no forward");
    idle();

    // sweep: every reserved address x store address x reserved length
    for (int ln = 0; ln < 3; ln++) begin
      for (int la = 0; la < (1 << AW); la++) begin
        for (int sa = 0; sa < (1 << AW); sa++) begin
          logic [LW-1:0] len_v;
          len_v = (ln == 0) ? 4'd4 : (ln == 1) ? 4'd2 : 4'd8;
          step(1, la[AW-1:0], len_v, 0, 0, 0, 0, 0, "R1 sweep");
          step(0, 0, 0, 1, sa[AW-1:0], 4, {32'h5A5A_0000 + 32'(la), 32'(sa) * 32'h0101_0101},
               0, "R4 sweep");
        end
      end
    end
    idle();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule